// File: doc/BRIEF.md
# Iterative Floating-Point Mantissa Divider

This unit divides one unpacked floating-point operand by another. Each operand is presented as a class code, a sign, a signed unbiased exponent and a normalized mantissa in [1,2). The mantissa carries its integer bit, the fraction bits and two extra low-order bits for later rounding. When either operand is zero, infinite or a NaN, the result is decided straight from the operand classes and is ready one cycle after the request. When both operands are normal numbers, the unit runs a restoring shift-and-subtract loop that yields one quotient bit per clock. The quotient mantissa is normalized, and a sticky bit records whether any remainder is left over.

A request is made by raising `start` for one cycle while `busy` is low. The operands are sampled on that edge. `done` then pulses for one cycle when the result fields are valid, and those fields hold their values until the next accepted request. Packing into a storage format, rounding and subnormal handling belong to the neighbouring units.

Top module: `fdiv_unit`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are low and every result output and flag is zero.
- R2: Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN and 4 signalling NaN. If either operand is a NaN, the result is one of the operands, returned unchanged in class, sign, exponent (sign-extended) and mantissa. A lone signalling NaN wins. If only one operand is a NaN, that operand is returned. In every other NaN case the divisor is returned. No flag is raised.
- R3: Infinity divided by infinity, and zero divided by zero, give a generated NaN: class 3, sign 0, exponent 0, and a mantissa whose two top bits are 1 and whose other bits are 0. `flag_invalid` is set.
- R4: Infinity divided by a normal number or by zero gives infinity. Zero divided by a normal number or by infinity gives zero, and so does a normal number divided by infinity. These results carry exponent 0, mantissa 0, sticky 0 and no flag.
- R5: A normal number divided by zero gives infinity with `flag_divzero` set.
- R6: For every result that is not a NaN, the sign is the XOR of the two operand signs.
- R7: A request with at least one non-normal operand raises `done` on the edge after the one that accepted it, and `busy` stays low throughout.
- R8: A request with two normal operands holds `busy` high for exactly MANT_W cycles after the accepting edge. `done` then pulses for one cycle, with `busy` already low.
- R9: The result exponent is the dividend exponent minus the divisor exponent when the dividend mantissa is not smaller than the divisor mantissa, and one less than that otherwise.
- R10: The result mantissa is the integer quotient of the dividend mantissa, scaled by 2^(MANT_W-1) (or by 2^MANT_W when it is smaller than the divisor mantissa), divided by the divisor mantissa. Its top bit is always 1.
- R11: The sticky bit is 1 exactly when that integer division leaves a nonzero remainder. It is 0 for every non-normal result.
- R12: A `start` raised while `busy` is high is ignored. While idle, the result outputs do not change until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted when busy is low |
| a_cls | input | 3 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EXP_W | Dividend unbiased exponent, two's complement |
| a_mant | input | MANT_W | Dividend mantissa, top bit is the integer bit |
| b_cls | input | 3 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EXP_W | Divisor unbiased exponent, two's complement |
| b_mant | input | MANT_W | Divisor mantissa, top bit is the integer bit |
| busy | output | 1 | Quotient loop in progress |
| done | output | 1 | One-cycle pulse: result valid |
| q_cls | output | 3 | Result class code |
| q_sign | output | 1 | Result sign |
| q_exp | output | EXP_W+1 | Result exponent, two's complement |
| q_mant | output | MANT_W | Result mantissa |
| q_sticky | output | 1 | Nonzero-remainder indicator |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_divzero | output | 1 | Divide-by-zero flag |

## Verification
The two corners that random operands almost never reach are a remainder that comes out exactly zero and a dividend mantissa only just below the divisor mantissa, where the exponent is decremented. The stimulus reaches both with constructed mantissa pairs: equal mantissas, a divisor of exactly 1.0, exact ratios such as 1.125 over 1.5, the largest mantissa over the smallest, and neighbouring values one unit apart. A second request is also raised in the middle of a running loop, to show that it changes neither the timing nor the result of the divide already under way.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fcls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STEP  = 2'd2
  } fdiv_state_e;

  function automatic logic cls_is_nan(input logic [2:0] c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction

endpackage

// File: rtl/fdiv_special.sv
module fdiv_special
  import fdiv_pkg::*;
#(
  parameter int MANT_W = 55,
  parameter int EXP_W  = 13
) (
  input  logic [2:0]        a_cls,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [2:0]        b_cls,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              special,
  output logic [2:0]        r_cls,
  output logic              r_sign,
  output logic [EXP_W:0]    r_exp,
  output logic [MANT_W-1:0] r_mant,
  output logic              r_invalid,
  output logic              r_divzero
);

  localparam logic [MANT_W-1:0] GEN_NAN_MANT = {2'b11, {(MANT_W-2){1'b0}}};

  logic a_nan, b_nan, take_b;

  always_comb begin
    a_nan   = cls_is_nan(a_cls);
    b_nan   = cls_is_nan(b_cls);
    take_b  = b_nan && !((a_cls == CLS_SNAN) && (b_cls != CLS_SNAN));
    special = !((a_cls == CLS_NORM) && (b_cls == CLS_NORM));

    r_cls     = CLS_ZERO;
    r_sign    = a_sign ^ b_sign;
    r_exp     = '0;
    r_mant    = '0;
    r_invalid = 1'b0;
    r_divzero = 1'b0;

    if (a_nan || b_nan) begin
      if (take_b) begin
        r_cls  = b_cls;
        r_sign = b_sign;
        r_exp  = {b_exp[EXP_W-1], b_exp};
        r_mant = b_mant;
      end else begin
        r_cls  = a_cls;
        r_sign = a_sign;
        r_exp  = {a_exp[EXP_W-1], a_exp};
        r_mant = a_mant;
      end
    end else if ((a_cls == CLS_INF) || (a_cls == CLS_ZERO)) begin
      if (a_cls == b_cls) begin
        r_cls     = CLS_QNAN;
        r_sign    = 1'b0;
        r_mant    = GEN_NAN_MANT;
        r_invalid = 1'b1;
      end else begin
        r_cls = a_cls;
      end
    end else if (b_cls == CLS_INF) begin
      r_cls = CLS_ZERO;
    end else if (b_cls == CLS_ZERO) begin
      r_cls     = CLS_INF;
      r_divzero = 1'b1;
    end
  end

endmodule

// File: rtl/fdiv_trial.sv
module fdiv_trial #(
  parameter int MANT_W = 55
) (
  input  logic [MANT_W-1:0] xm,
  input  logic [MANT_W-1:0] ym,
  output logic [MANT_W:0]   rem,
  output logic              dec
);

  logic [MANT_W:0] once;
  logic [MANT_W:0] twice;

  always_comb begin
    once  = {1'b0, xm} - {1'b0, ym};
    twice = {xm, 1'b0} - {1'b0, ym};
    dec   = once[MANT_W];
    rem   = dec ? twice : once;
  end

endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
  parameter int MANT_W = 55
) (
  input  logic [MANT_W:0]   rem_in,
  input  logic [MANT_W-1:0] ym,
  output logic [MANT_W:0]   rem_out,
  output logic              qbit
);

  logic [MANT_W:0] shifted;
  logic [MANT_W:0] diff;
  logic            borrow;

  always_comb begin
    shifted        = rem_in << 1;
    {borrow, diff} = {1'b0, shifted} - {2'b00, ym};
    qbit           = !borrow;
    rem_out        = borrow ? shifted : diff;
  end

endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int STEPS = 54
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic special,
  output logic busy,
  output logic done,
  output logic accept,
  output logic setup_en,
  output logic step_en,
  output logic last
);

  localparam int CNT_W = $clog2(STEPS + 1);

  fdiv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    accept   = start && (state_q == ST_IDLE);
    setup_en = (state_q == ST_SETUP);
    step_en  = (state_q == ST_STEP);
    last     = step_en && (cnt_q == CNT_W'(1));
    busy     = (state_q != ST_IDLE);
    done     = done_q;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = (accept && special) || last;
    case (state_q)
      ST_IDLE: begin
        if (accept && !special) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d = ST_STEP;
        cnt_d   = CNT_W'(STEPS);
        cnt_en  = 1'b1;
      end
      ST_STEP: begin
        cnt_d  = cnt_q - CNT_W'(1);
        cnt_en = 1'b1;
        if (last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fdiv_unit.sv
module fdiv_unit
  import fdiv_pkg::*;
#(
  parameter int MANT_W = 55,
  parameter int EXP_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        a_cls,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [2:0]        b_cls,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              busy,
  output logic              done,
  output logic [2:0]        q_cls,
  output logic              q_sign,
  output logic [EXP_W:0]    q_exp,
  output logic [MANT_W-1:0] q_mant,
  output logic              q_sticky,
  output logic              flag_invalid,
  output logic              flag_divzero
);

  localparam int STEPS = MANT_W - 1;
  localparam int RW    = MANT_W + 1;
  localparam int XW    = EXP_W + 1;

  logic              special, accept, setup_en, step_en, last;
  logic [2:0]        sp_cls;
  logic              sp_sign, sp_inv, sp_dz;
  logic [XW-1:0]     sp_exp;
  logic [MANT_W-1:0] sp_mant;
  logic [RW-1:0]     tr_rem, st_rem;
  logic              tr_dec, st_bit;

  logic [RW-1:0]     rem_q, rem_d;
  logic [MANT_W-1:0] ym_q, ym_d;
  logic [MANT_W-1:0] quo_q, quo_d;
  logic [XW-1:0]     exp_q, exp_d;
  logic [2:0]        cls_q, cls_d;
  logic              sign_q, sign_d;
  logic              sticky_q, sticky_d;
  logic              inv_q, inv_d;
  logic              dz_q, dz_d;
  logic              res_en, ym_en;

  fdiv_special #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_special (
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .special(special), .r_cls(sp_cls), .r_sign(sp_sign), .r_exp(sp_exp),
    .r_mant(sp_mant), .r_invalid(sp_inv), .r_divzero(sp_dz)
  );

  fdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .special(special),
    .busy(busy), .done(done), .accept(accept), .setup_en(setup_en),
    .step_en(step_en), .last(last)
  );

  fdiv_trial #(.MANT_W(MANT_W)) u_trial (
    .xm(rem_q[MANT_W-1:0]), .ym(ym_q), .rem(tr_rem), .dec(tr_dec)
  );

  fdiv_step #(.MANT_W(MANT_W)) u_step (
    .rem_in(rem_q), .ym(ym_q), .rem_out(st_rem), .qbit(st_bit)
  );

  always_comb begin
    rem_d    = rem_q;
    ym_d     = ym_q;
    quo_d    = quo_q;
    exp_d    = exp_q;
    cls_d    = cls_q;
    sign_d   = sign_q;
    sticky_d = sticky_q;
    inv_d    = inv_q;
    dz_d     = dz_q;
    res_en   = accept || setup_en || step_en;
    ym_en    = accept && !special;

    if (accept) begin
      sticky_d = 1'b0;
      if (special) begin
        cls_d  = sp_cls;
        sign_d = sp_sign;
        exp_d  = sp_exp;
        quo_d  = sp_mant;
        rem_d  = '0;
        inv_d  = sp_inv;
        dz_d   = sp_dz;
      end else begin
        cls_d  = CLS_NORM;
        sign_d = a_sign ^ b_sign;
        exp_d  = {a_exp[EXP_W-1], a_exp} - {b_exp[EXP_W-1], b_exp};
        quo_d  = '0;
        rem_d  = {1'b0, a_mant};
        ym_d   = b_mant;
        inv_d  = 1'b0;
        dz_d   = 1'b0;
      end
    end else if (setup_en) begin
      rem_d = tr_rem;
      quo_d = MANT_W'(1);
      exp_d = exp_q - XW'(tr_dec);
    end else if (step_en) begin
      rem_d = st_rem;
      quo_d = {quo_q[MANT_W-2:0], st_bit};
      if (last) sticky_d = |st_rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      quo_q    <= '0;
      exp_q    <= '0;
      cls_q    <= '0;
      sign_q   <= 1'b0;
      sticky_q <= 1'b0;
      inv_q    <= 1'b0;
      dz_q     <= 1'b0;
    end else if (res_en) begin
      rem_q    <= rem_d;
      quo_q    <= quo_d;
      exp_q    <= exp_d;
      cls_q    <= cls_d;
      sign_q   <= sign_d;
      sticky_q <= sticky_d;
      inv_q    <= inv_d;
      dz_q     <= dz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ym_q <= '0;
    else if (ym_en) ym_q <= ym_d;
  end

  assign q_cls        = cls_q;
  assign q_sign       = sign_q;
  assign q_exp        = exp_q;
  assign q_mant       = quo_q;
  assign q_sticky     = sticky_q;
  assign flag_invalid = inv_q;
  assign flag_divzero = dz_q;

endmodule

// File: rtl/fdiv_unit_chk.sv
module fdiv_unit_chk
  import fdiv_pkg::*;
#(
  parameter int MANT_W = 55,
  parameter int EXP_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        a_cls,
  input logic [2:0]        b_cls,
  input logic              busy,
  input logic              done,
  input logic [2:0]        q_cls,
  input logic [MANT_W-1:0] q_mant,
  input logic              q_sticky,
  input logic              flag_invalid,
  input logic              flag_divzero
);

  localparam int CW = $clog2(MANT_W + 2);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + CW'(1);
    else           busy_cnt <= '0;
  end

  a_r7_special_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !((a_cls == CLS_NORM) && (b_cls == CLS_NORM))) |=> (done && !busy));

  a_r8_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  a_r8_loop_length: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> (busy_cnt == CW'(MANT_W)));

  a_r10_msb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (q_cls == CLS_NORM)) |-> q_mant[MANT_W-1]);

  a_r11_special_no_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (q_cls != CLS_NORM)) |-> !q_sticky);

  a_r3_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (q_cls == CLS_QNAN));

  a_r5_divzero_inf: assert property (@(posedge clk) disable iff (!rst_n)
    flag_divzero |-> (q_cls == CLS_INF));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(q_mant) && $stable(q_cls) && $stable(q_sticky)));

endmodule

bind fdiv_unit fdiv_unit_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a_cls(a_cls), .b_cls(b_cls),
  .busy(busy), .done(done), .q_cls(q_cls), .q_mant(q_mant),
  .q_sticky(q_sticky), .flag_invalid(flag_invalid), .flag_divzero(flag_divzero)
);

// File: tb/sim_fdiv_unit.sv
module sim_fdiv_unit;
  import fdiv_pkg::*;

  localparam int MW = 55;
  localparam int EW = 13;
  localparam int NW = 2 * MW + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start;
  logic [2:0]    a_cls, b_cls;
  logic          a_sign, b_sign;
  logic [EW-1:0] a_exp, b_exp;
  logic [MW-1:0] a_mant, b_mant;
  logic          busy, done, q_sign, q_sticky, flag_invalid, flag_divzero;
  logic [2:0]    q_cls;
  logic [EW:0]   q_exp;
  logic [MW-1:0] q_mant;

  int vecs = 0;
  int errs = 0;

  fdiv_unit #(.MANT_W(MW), .EXP_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .busy(busy), .done(done), .q_cls(q_cls), .q_sign(q_sign), .q_exp(q_exp),
    .q_mant(q_mant), .q_sticky(q_sticky), .flag_invalid(flag_invalid),
    .flag_divzero(flag_divzero)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam logic [MW-1:0] ONE  = MW'(1) << (MW - 1);
  localparam logic [MW-1:0] MAXM = '1;

  task automatic run(input string tag,
                     input logic [2:0] ac, input logic as, input int ae, input logic [MW-1:0] am,
                     input logic [2:0] bc, input logic bs, input int be, input logic [MW-1:0] bm,
                     input bit inject);
    logic          e_spec, e_sign, e_stk, e_inv, e_dz, an, bn, pick_b;
    logic [2:0]    e_cls;
    int            e_exp, lat;
    logic [MW-1:0] e_mant;
    logic [NW-1:0] num, qq, rr;
    an = (ac == CLS_QNAN) || (ac == CLS_SNAN);
    bn = (bc == CLS_QNAN) || (bc == CLS_SNAN);
    e_spec = !((ac == CLS_NORM) && (bc == CLS_NORM));
    e_sign = as ^ bs; e_exp = 0; e_mant = '0; e_stk = 0; e_inv = 0; e_dz = 0;
    e_cls = CLS_ZERO;
    if (an || bn) begin
      pick_b = bn && !((ac == CLS_SNAN) && (bc != CLS_SNAN));
      e_cls  = pick_b ? bc : ac;
      e_sign = pick_b ? bs : as;
      e_exp  = pick_b ? be : ae;
      e_mant = pick_b ? bm : am;
    end else if ((ac == CLS_INF || ac == CLS_ZERO) && ac == bc) begin
      e_cls = CLS_QNAN; e_sign = 0; e_mant = {2'b11, {(MW-2){1'b0}}}; e_inv = 1;
    end else if (ac == CLS_INF || ac == CLS_ZERO) begin
      e_cls = ac;
    end else if (bc == CLS_INF) begin
      e_cls = CLS_ZERO;
    end else if (bc == CLS_ZERO) begin
      e_cls = CLS_INF; e_dz = 1;
    end else begin
      e_cls = CLS_NORM;
      if (am >= bm) begin num = NW'(am) << (MW - 1); e_exp = ae - be; end
      else          begin num = NW'(am) << MW;       e_exp = ae - be - 1; end
      qq = num / NW'(bm);
      rr = num % NW'(bm);
      e_mant = qq[MW-1:0];
      e_stk  = (rr != 0);
    end
    lat = e_spec ? 1 : MW + 1;

    @(negedge clk);
    start = 1; a_cls = ac; a_sign = as; a_exp = EW'(ae); a_mant = am;
    b_cls = bc; b_sign = bs; b_exp = EW'(be); b_mant = bm;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k < lat) begin
        chk({tag, " R8 busy during loop"}, 128'(busy), 128'(1));
        chk({tag, " R8 no early done"}, 128'(done), 128'(0));
      end else begin
        chk({tag, e_spec ? " R7 done" : " R8 done"}, 128'(done), 128'(1));
        chk({tag, " R8 busy low at done"}, 128'(busy), 128'(0));
        chk({tag, " class"}, 128'(q_cls), 128'(e_cls));
        chk({tag, " R6 sign"}, 128'(q_sign), 128'(e_sign));
        chk({tag, " R9 exponent"}, 128'(int'($signed(q_exp))), 128'(e_exp));
        chk({tag, " R10 mantissa"}, 128'(q_mant), 128'(e_mant));
        chk({tag, " R11 sticky"}, 128'(q_sticky), 128'(e_stk));
        chk({tag, " R3 invalid flag"}, 128'(flag_invalid), 128'(e_inv));
        chk({tag, " R5 divzero flag"}, 128'(flag_divzero), 128'(e_dz));
      end
      if (k == 1) start = 0;
      if (inject && k == 3) begin
        start = 1; a_cls = CLS_INF; b_cls = CLS_INF; a_mant = '0; b_mant = '0;
      end
      if (inject && k == 4) start = 0;
    end
    @(negedge clk);
    chk({tag, " R12 done dropped"}, 128'(done), 128'(0));
    chk({tag, " R12 mantissa held"}, 128'(q_mant), 128'(e_mant));
    chk({tag, " R12 class held"}, 128'(q_cls), 128'(e_cls));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [63:0] r1, r2;
    rst_n = 0; start = 0;
    a_cls = '0; a_sign = 0; a_exp = '0; a_mant = '0;
    b_cls = '0; b_sign = 0; b_exp = '0; b_mant = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 128'(busy), 128'(0));
    chk("R1 mantissa in reset", 128'(q_mant), 128'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", 128'(done), 128'(0));
    chk("R1 flags after reset", 128'({flag_invalid, flag_divzero, q_sticky}), 128'(0));
    chk("R1 class after reset", 128'(q_cls), 128'(0));

    // R2 NaN selection
    run("R2 qnan/num",   CLS_QNAN, 1, 7, ONE | 5, CLS_NORM, 0, 3, ONE, 0);
    run("R2 num/snan",   CLS_NORM, 0, 1, ONE, CLS_SNAN, 1, -9, ONE | 3, 0);
    run("R2 snan/qnan",  CLS_SNAN, 0, -4, ONE | 9, CLS_QNAN, 1, 2, ONE | 1, 0);
    run("R2 qnan/snan",  CLS_QNAN, 0, 5, ONE | 2, CLS_SNAN, 0, 6, ONE | 4, 0);
    run("R2 qnan/qnan",  CLS_QNAN, 1, 8, ONE | 6, CLS_QNAN, 0, -1, ONE | 7, 0);
    run("R2 snan/snan",  CLS_SNAN, 1, 8, ONE | 6, CLS_SNAN, 0, -1, ONE | 8, 0);
    run("R2 inf/qnan",   CLS_INF, 0, 0, '0, CLS_QNAN, 1, 4, ONE | 11, 0);
    // R3 invalid
    run("R3 inf/inf",    CLS_INF, 1, 0, '0, CLS_INF, 0, 0, '0, 0);
    run("R3 zero/zero",  CLS_ZERO, 0, 0, '0, CLS_ZERO, 1, 0, '0, 0);
    // R4 pass-through classes
    run("R4 inf/num",    CLS_INF, 1, 0, '0, CLS_NORM, 1, 3, ONE, 0);
    run("R4 inf/zero",   CLS_INF, 0, 0, '0, CLS_ZERO, 1, 0, '0, 0);
    run("R4 zero/num",   CLS_ZERO, 1, 0, '0, CLS_NORM, 0, 3, ONE, 0);
    run("R4 zero/inf",   CLS_ZERO, 0, 0, '0, CLS_INF, 0, 0, '0, 0);
    run("R4 num/inf",    CLS_NORM, 1, 12, MAXM, CLS_INF, 0, 0, '0, 0);
    // R5 divide by zero
    run("R5 num/zero",   CLS_NORM, 0, -3, ONE | 1, CLS_ZERO, 1, 0, '0, 0);
    run("R5 num/zero+",  CLS_NORM, 1, 3, MAXM, CLS_ZERO, 1, 0, '0, 0);
    // R9 R10 R11 normal divides
    run("R10 equal",        CLS_NORM, 0, 5, ONE | 77, CLS_NORM, 1, 5, ONE | 77, 0);
    run("R10 by one",       CLS_NORM, 1, 10, MAXM, CLS_NORM, 1, -10, ONE, 0);
    run("R9 exact below",   CLS_NORM, 0, 0, MW'(9) << (MW - 4), CLS_NORM, 0, 0, MW'(3) << (MW - 2), 0);
    run("R11 thirds",       CLS_NORM, 0, 2, ONE, CLS_NORM, 0, 1, MW'(3) << (MW - 2), 0);
    run("R9 one over max",  CLS_NORM, 1, -2000, ONE, CLS_NORM, 0, 2000, MAXM, 0);
    run("R9 max over one",  CLS_NORM, 0, 4095, MAXM, CLS_NORM, 0, -4096, ONE, 0);
    run("R9 one ulp below", CLS_NORM, 0, 1, MAXM - 1, CLS_NORM, 1, 1, MAXM, 0);
    run("R9 one ulp above", CLS_NORM, 1, 1, ONE | 1, CLS_NORM, 1, 1, ONE, 0);
    // R12 start while busy
    run("R12 inject",       CLS_NORM, 1, 7, ONE | 12345, CLS_NORM, 0, 2, ONE | 999, 1);
    for (int i = 0; i < 40; i++) begin
      r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom};
      run("R10 random", CLS_NORM, r1[60], int'($urandom_range(4000)) - 2000, {1'b1, r1[MW-2:0]},
          CLS_NORM, r2[61], int'($urandom_range(4000)) - 2000, {1'b1, r2[MW-2:0]}, (i % 8) == 3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule